// File: doc/BRIEF.md
# UART Transmit Holding Path

This block is the send side of a 16550-class serial port. A host writes characters one byte at a time through a write strobe. The characters wait in storage and then go one by one into a shift register that puts them on the serial line. Each character is sent as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts a fixed number of oversampling ticks, and those ticks arrive from an external baud generator.

The storage has two modes. In queued mode it is a 16-deep first-in first-out buffer. In single mode it is one holding register, and a new write replaces a character that has not yet been taken. The block reports two status flags: holding-empty, which is set when the storage is empty, and transmitter-empty, which is set when the storage and the shift register are both empty. It also raises a gated interrupt request while holding-empty is set.

A flush pulse discards the queued characters. A change of mode also discards them. In both cases a character that is already being shifted out finishes unchanged.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `txd` is 1, `thre` is 1, `temt` is 1 and `thre_irq` is 0 while `thre_ie` is 0.
- R2: A frame is one 0 start bit, then the eight data bits with bit 0 first, then one 1 stop bit. Each bit holds for OSR=16 clock cycles in which `baud_tick` is 1. The line is 1 whenever no frame is being sent.
- R3: In queued mode (`fifo_en`=1), up to 16 waiting characters are kept and sent in the order they were written. A write is ignored when 16 characters are waiting at that cycle.
- R4: In single mode (`fifo_en`=0), one character waits. A write while it is occupied replaces the waiting character.
- R5: `thre` is 1 exactly when no character is waiting. It falls on the clock edge that takes a write into empty storage, and it rises on the edge that moves the last waiting character into the shift register.
- R6: `temt` is 1 exactly when no character is waiting and no frame is being sent.
- R7: `thre_irq` is 1 exactly when `thre` and `thre_ie` are both 1.
- R8: A `tx_clr` pulse in queued mode discards every waiting character, and a frame in progress completes unchanged. In single mode `tx_clr` has no effect.
- R9: A change of `fifo_en` discards every waiting character and ignores a write in that same cycle. A frame in progress completes unchanged.
- R10: With the shifter idle, a written character starts its frame one clock after the write edge, so `txd` falls on the second edge after the write strobe is seen. After a stop bit ends, the next waiting character starts one clock later, so two back-to-back frames start 161 cycles apart when `baud_tick` is 1 every cycle.
- R11: In single mode, when a write coincides with the cycle in which the waiting character moves into the shifter, the old character is sent and the new one stays waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queued mode, 0 selects single mode |
| wr_stb | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to send |
| tx_clr | input | 1 | Flush pulse for waiting characters (queued mode only) |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| thre_ie | input | 1 | Holding-empty interrupt enable |
| txd | output | 1 | Serial output, idles at 1 |
| thre | output | 1 | Holding-empty flag |
| temt | output | 1 | Transmitter-empty flag |
| thre_irq | output | 1 | Holding-empty interrupt request |

## Verification
Two actions can fall in the same cycle: a host write, and the move of a waiting character into the idle shifter. The bench provokes this directly in single mode. It writes three characters on consecutive cycles, so the second write lands on the cycle in which the first character is moved into the shifter. The bench then decodes the line and expects only the first and the third characters to appear.

The same coincidence occurs many times in the random phase, together with flushes and mode changes landing on load cycles. A requirement-level model of the storage and the frame timing predicts `txd`, `thre` and `temt` every cycle. The decoded characters are compared against the order in which that model loaded them.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic {
      SH_IDLE = 1'b0,
      SH_RUN  = 1'b1
   } sh_state_t;
endpackage

// File: rtl/uart_tx_store.sv
// Character storage: a circular queue in queued mode, one slot in single mode.
module uart_tx_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fifo_mode,
   input  logic                      flush,
   input  logic                      wr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic                      pop,
   output logic [DATA_W-1:0]         rdata,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     rp, wp;
   logic              accept;

   assign accept = fifo_mode ? (wr && (count < CW'(DEPTH))) : wr;
   assign rdata  = mem[rp];

   always_ff @(posedge clk) begin
      if (accept && !flush) begin
         if (fifo_mode) mem[wp] <= wdata;
         else           mem[rp] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else if (flush) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else if (fifo_mode) begin
         if (accept) wp <= wp + 1'b1;
         if (pop)    rp <= rp + 1'b1;
         count <= count + CW'(accept) - CW'(pop);
      end else begin
         if (accept)   count <= CW'(1);
         else if (pop) count <= '0;
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && wr && !pop && !flush && count == CW'(DEPTH)) |=> count == CW'(DEPTH));
   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0);
   assert_single_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_mode && !flush && wr) |=> count == CW'(1));
endmodule

// File: rtl/uart_tx_shift.sv
// Serialiser: start bit, data least significant first, stop bit, OSR ticks per bit.
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] ldata,
   output logic              ready,
   output logic              txd
);
   localparam int FRAME = DATA_W + 2;
   localparam int BW    = $clog2(FRAME);
   localparam int TW    = $clog2(OSR);

   sh_state_t        state;
   logic [FRAME-1:0] shreg;
   logic [TW-1:0]    tcnt;
   logic [BW-1:0]    bcnt;

   assign ready = (state == SH_IDLE);
   assign txd   = (state == SH_RUN) ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         shreg <= '1;
         tcnt  <= '0;
         bcnt  <= '0;
      end else if (load) begin
         state <= SH_RUN;
         shreg <= {1'b1, ldata, 1'b0};
         tcnt  <= '0;
         bcnt  <= '0;
      end else if (state == SH_RUN && tick) begin
         if (tcnt == TW'(OSR-1)) begin
            tcnt <= '0;
            if (bcnt == BW'(FRAME-1)) begin
               state <= SH_IDLE;
            end else begin
               shreg <= {1'b1, shreg[FRAME-1:1]};
               bcnt  <= bcnt + 1'b1;
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);
   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_IDLE) |-> txd);
   assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_RUN && bcnt == BW'(FRAME-1)) |-> txd);
   assert_load_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> state == SH_IDLE);
endmodule

// File: rtl/uart_tx_hold.sv
// Transmit holding path top: storage, serialiser, status flags.
module uart_tx_hold #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_clr,
   input  logic              baud_tick,
   input  logic              thre_ie,
   output logic              txd,
   output logic              thre,
   output logic              temt,
   output logic              thre_irq
);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("uart_tx_hold: DEPTH must be a power of two, at least 2");
      end
      if (OSR < 2 || (OSR & (OSR-1)) != 0) begin : g_bad_osr
         $error("uart_tx_hold: OSR must be a power of two, at least 2");
      end
      if (DATA_W < 5) begin : g_bad_width
         $error("uart_tx_hold: DATA_W must be at least 5");
      end
   endgenerate

   logic              fifo_q;
   logic              mode_flip;
   logic              flush;
   logic              pop;
   logic              sh_ready;
   logic              empty;
   logic [CW-1:0]     count;
   logic [DATA_W-1:0] head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fifo_q <= 1'b0;
      else        fifo_q <= fifo_en;
   end

   assign mode_flip = fifo_en ^ fifo_q;
   assign flush     = mode_flip | (tx_clr & fifo_en);
   assign empty     = (count == '0);
   assign pop       = sh_ready & ~empty & ~flush;

   uart_tx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_mode (fifo_en),
      .flush     (flush),
      .wr        (wr_stb),
      .wdata     (wr_data),
      .pop       (pop),
      .rdata     (head),
      .count     (count)
   );

   uart_tx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (baud_tick),
      .load  (pop),
      .ldata (head),
      .ready (sh_ready),
      .txd   (txd)
   );

   assign thre     = empty;
   assign temt     = empty & sh_ready;
   assign thre_irq = thre & thre_ie;

   assert_temt_needs_thre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      temt |-> thre);
   assert_mode_flip_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_flip |=> thre);
   assert_idle_takes_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_ready && !thre && !flush) |=> !sh_ready);
   assert_busy_line_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> !temt);
endmodule

// File: tb/sim_uart_tx_hold.sv
module sim_uart_tx_hold;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tx_clr = 1'b0;
   logic       baud_tick = 1'b0;
   logic       thre_ie = 1'b0;
   logic       txd, thre, temt, thre_irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // 50 MHz: 20 ns period
   always #10 clk = ~clk;

   uart_tx_hold u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_stb(wr_stb),
      .wr_data(wr_data), .tx_clr(tx_clr), .baud_tick(baud_tick),
      .thre_ie(thre_ie), .txd(txd), .thre(thre), .temt(temt),
      .thre_irq(thre_irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Requirement-level model of storage and frame timing
   logic [7:0] mq[$];
   logic [7:0] exp_line[$];
   logic [7:0] rx[$];
   int         starts[$];
   bit         m_busy = 0;
   int         m_n = 0;
   logic [9:0] m_frame = '1;
   bit         m_fq = 0;
   // line decoder
   bit         d_on = 0;
   int         d_n = 0;
   logic [9:0] d_bits;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         mq.delete(); m_busy = 0; m_n = 0; m_fq = 0; d_on = 0;
      end else begin
         bit fl, pp;
         int sz;
         fl = (fifo_en != m_fq) || (tx_clr && fifo_en);
         pp = !m_busy && mq.size() > 0 && !fl;
         sz = mq.size();
         if (m_busy && baud_tick) begin
            m_n++;
            if (m_n == 160) m_busy = 0;
         end
         if (pp) begin
            m_busy = 1; m_n = 0;
            m_frame = {1'b1, mq[0], 1'b0};
            exp_line.push_back(mq[0]);
         end
         if (fl) mq.delete();
         else begin
            if (pp) void'(mq.pop_front());
            if (wr_stb) begin
               if (fifo_en) begin
                  if (sz < 16) mq.push_back(wr_data);
               end else if (mq.size() == 0) mq.push_back(wr_data);
               else mq[0] = wr_data;
            end
         end
         m_fq = fifo_en;
         // decoder: count ticks consumed at the edge just past
         if (!d_on && txd == 1'b0) begin
            d_on = 1; d_n = 0; starts.push_back(cyc);
         end else if (d_on && baud_tick) begin
            d_n++;
            if (d_n % 16 == 8) begin
               d_bits[d_n/16] = txd;
               if (d_n / 16 == 9) begin
                  d_on = 0;
                  chk("R2 start bit", d_bits[0], 0);
                  chk("R2 stop bit", d_bits[9], 1);
                  rx.push_back(d_bits[8:1]);
                  if (exp_line.size() == 0) chk("R2 unexpected frame", 1, 0);
                  else chk("R3 order on line", d_bits[8:1], exp_line.pop_front());
               end
            end
         end
      end
   end

   function automatic logic exp_txd();
      if (!m_busy) return 1'b1;
      return m_frame[m_n/16];
   endfunction

   task automatic step(bit w, logic [7:0] d, bit c, bit f, bit t);
      @(negedge clk);
      #1;
      if (rst_n) begin
         chk("R2 txd", txd, exp_txd());
         chk("R5 thre", thre, mq.size() == 0);
         chk("R6 temt", temt, mq.size() == 0 && !m_busy);
         chk("R7 irq", thre_irq, (mq.size() == 0) && thre_ie);
      end
      wr_stb = w; wr_data = d; tx_clr = c; fifo_en = f; baud_tick = t;
   endtask

   task automatic idle(int n, bit f);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, f, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 txd", txd, 1);
      chk("R1 thre", thre, 1);
      chk("R1 temt", temt, 1);
      chk("R1 irq", thre_irq, 0);
      rst_n = 1'b1;
      idle(2, 0);

      // R10 / R5 single-mode write timing
      step(1, 8'hA5, 0, 0, 1);
      step(0, 8'h00, 0, 0, 1);
      chk("R5 thre low after write", thre, 0);
      chk("R6 temt low after write", temt, 0);
      chk("R10 line still idle", txd, 1);
      step(0, 8'h00, 0, 0, 1);
      chk("R10 start bit one clock later", txd, 0);
      chk("R5 thre high after load", thre, 1);
      chk("R6 temt low while sending", temt, 0);
      idle(200, 0);

      // R10 back-to-back spacing in queued mode
      idle(3, 1);
      rx.delete(); starts.delete();
      step(1, 8'h3C, 0, 1, 1);
      step(1, 8'hC3, 0, 1, 1);
      idle(400, 1);
      chk("R10 frame count", rx.size(), 2);
      if (starts.size() == 2) chk("R10 start spacing", starts[1] - starts[0], 161);
      else chk("R10 start count", starts.size(), 2);
      if (rx.size() == 2) begin
         chk("R2 first char", rx[0], 8'h3C);
         chk("R2 second char", rx[1], 8'hC3);
      end

      // R3 overflow: 17 accepted (1 shifting + 16 waiting), 18th dropped
      rx.delete();
      for (int i = 0; i < 18; i++) step(1, 8'h40 + 8'(i), 0, 1, 0);
      step(0, 8'h00, 0, 1, 0);
      chk("R3 full not empty", thre, 0);
      idle(18 * 161 + 50, 1);
      chk("R3 accepted count", rx.size(), 17);
      for (int i = 0; i < 17 && i < rx.size(); i++)
         chk("R3 queue order", rx[i], 8'h40 + 8'(i));
      chk("R6 temt after drain", temt, 1);

      // R4 / R11 single-mode overwrite and write-at-load
      idle(3, 0);
      rx.delete();
      step(1, 8'h11, 0, 0, 1);
      step(1, 8'h22, 0, 0, 1);
      step(1, 8'h33, 0, 0, 1);
      chk("R11 new char waits", thre, 0);
      step(0, 8'h00, 0, 0, 1);
      idle(400, 0);
      chk("R4 frame count", rx.size(), 2);
      if (rx.size() == 2) begin
         chk("R11 old char sent", rx[0], 8'h11);
         chk("R4 replaced char sent", rx[1], 8'h33);
      end

      // R8 flush in queued mode
      idle(3, 1);
      rx.delete();
      step(1, 8'h55, 0, 1, 1);
      step(1, 8'h66, 0, 1, 1);
      step(1, 8'h77, 0, 1, 1);
      idle(20, 1);
      step(0, 8'h00, 1, 1, 1);
      step(0, 8'h00, 0, 1, 1);
      chk("R8 flushed storage empty", thre, 1);
      chk("R8 frame still running", temt, 0);
      idle(400, 1);
      chk("R8 only shifting char", rx.size(), 1);
      if (rx.size() == 1) chk("R8 char intact", rx[0], 8'h55);

      // R8 flush ignored in single mode
      idle(3, 0);
      rx.delete();
      step(1, 8'h88, 0, 0, 1);
      step(1, 8'h99, 0, 0, 1);
      step(0, 8'h00, 1, 0, 1);
      step(0, 8'h00, 0, 0, 1);
      chk("R8 single-mode clr ignored", thre, 0);
      idle(400, 0);
      chk("R8 single-mode frames", rx.size(), 2);
      if (rx.size() == 2) chk("R8 held char sent", rx[1], 8'h99);

      // R9 mode change discards waiting chars
      idle(3, 1);
      rx.delete();
      step(1, 8'hA1, 0, 1, 1);
      step(1, 8'hA2, 0, 1, 1);
      step(1, 8'hA3, 0, 1, 1);
      step(0, 8'h00, 0, 0, 1);
      step(0, 8'h00, 0, 0, 1);
      chk("R9 storage emptied", thre, 1);
      idle(400, 0);
      chk("R9 only shifting char", rx.size(), 1);
      if (rx.size() == 1) chk("R9 char intact", rx[0], 8'hA1);
      chk("R9 temt at end", temt, 1);

      // R7 interrupt gating
      thre_ie = 1'b1;
      step(0, 8'h00, 0, 0, 1);
      chk("R7 irq when empty", thre_irq, 1);
      step(1, 8'h5A, 0, 0, 0);
      step(0, 8'h00, 0, 0, 0);
      chk("R7 irq drops with char", thre_irq, 0);
      idle(400, 0);

      // Random phases
      for (int ph = 0; ph < 3; ph++) begin
         int tdiv;
         bit f;
         tdiv = (ph == 0) ? 1 : (ph == 1 ? 3 : 2);
         thre_ie = ph[0];
         f = fifo_en;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom % 800 == 0) f = !f;
            step(($urandom % 4) == 0, 8'($urandom), ($urandom % 200) == 0, f,
                 ($urandom % tdiv) == 0);
         end
      end
      idle(3000, fifo_en);
      chk("R3 all loaded chars seen", exp_line.size(), 0);
      chk("R6 final temt", temt, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule